// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a memory-mapped SPI master with a 32-bit register bus. Software loads words into a four-entry transmit queue, programs the frame length (bits minus one), the clock phase, the idle clock behaviour and the clock divider, then sets a start bit. The engine shifts out one frame of 1 to 32 bits, most significant bit first, and collects MISO into a four-entry receive queue. The received bits are right-aligned.

Chip select is either under direct software control, through a value bit and a polarity bit over up to four lines, or generated by the hardware around each frame. The hardware mode has an option to hold the line asserted between frames. Event flags are sticky and are cleared by writing 1 to them, so writing back a status value just read clears every pending event.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, command, command2, divider and fill-count registers read 0, and status reads 0x00A0_0000 (RX empty bit 23, TX empty bit 21). Command fields read back as written: enable 31, master select 28, idle mode 25:24, phase 21, CS polarity 13, CS value 12, software CS 11, length 4:0. The start bit (30) always reads back 0 once the frame has begun.
- R2: A frame carries bits len..0 of the TX word, most significant first on MOSI. Phase 0 samples MISO on the leading clock edges and phase 1 on the trailing ones. The captured bits land right-aligned in the RX word, with zeros above them.
- R3: Writing the start bit launches one frame only when enable is written 1 in the same write and the engine is idle. The start bit clears itself when the frame begins, and a start written while busy is ignored.
- R4: Status busy (bit 31) is 1 for the whole frame. Ready (bit 30) becomes 1 one cycle after busy falls.
- R5: SCLK half period is DIV+1 system cycles, with DIV at offset 0x0C. A frame thus takes 1+2(len+1)(DIV+1) cycles from the start write to busy falling. When idle, SCLK sits at idle mode bit 0, and the weak-drive output follows idle mode bit 1.
- R6: The TX queue holds 4 words, written at offset 0x100. Status2 bits 2:0 give its fill count, and TX full (bit 20) is reported. A write to a full queue is dropped and sets TX overflow (bit 19).
- R7: A read at 0x180 pops the RX queue. A read while empty returns 0 and sets RX underrun (bit 18). A completed frame arriving with the queue full is dropped and sets RX overflow (bit 25). Status2 bits 18:16 give the RX fill count.
- R8: Ready, RX overflow, TX underrun, TX overflow and RX underrun are sticky and are cleared by writing 1 to them. Writing back a status value just read clears them all.
- R9: Error (status bit 29) is 1 exactly while any of the four overflow or underrun flags is set.
- R10: A frame started with an empty TX queue shifts zeros and sets TX underrun (bit 24).
- R11: With transmit enable (command2 bit 30) off, a frame shifts zeros and leaves the TX queue untouched. With receive enable (bit 31) off, nothing is pushed into the RX queue.
- R12: With software CS on, the line chosen by command2 bits 19:18 is asserted while the CS value bit is 1, at the level given by the polarity bit (0 = active low). All other lines stay inactive.
- R13: With software CS off, the chosen line is asserted from frame start to frame end. If the keep bit (command2 bit 17) is set, it stays asserted after the frame until keep is cleared.
- R14: Writing 1 to status bit 26 empties the TX queue and writing 1 to bit 27 empties the RX queue. Both bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| sclk_o | output | 1 | SPI clock |
| sclk_weak_o | output | 1 | 1 = idle clock held by weak pull instead of drive |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 4 | Chip select lines |

## Verification
Random frames mix all lengths from 1 to 32 bits, dividers 0 to 3, both phases and all four idle modes. MISO is looped back from MOSI, either straight or inverted. A monitor on SCLK rebuilds the word from the edges the chosen phase names, so a reversed bit order, a wrong sampling edge or a length off by one shows up as a mismatch. The inverted loopback tells a correct receive path apart from one that merely echoes the TX word. Directed cases fill and overflow each queue, start with an empty queue or with a path disabled, restart while busy, and exercise every chip-select mode and polarity.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ADDR_W = 9;
  localparam logic [ADDR_W-1:0] A_CMD   = 9'h000;
  localparam logic [ADDR_W-1:0] A_CMD2  = 9'h004;
  localparam logic [ADDR_W-1:0] A_STAT  = 9'h008;
  localparam logic [ADDR_W-1:0] A_DIV   = 9'h00C;
  localparam logic [ADDR_W-1:0] A_STAT2 = 9'h01C;
  localparam logic [ADDR_W-1:0] A_TXP   = 9'h100;
  localparam logic [ADDR_W-1:0] A_RXP   = 9'h180;

  // status bit positions
  localparam int S_BUSY = 31, S_RDY = 30, S_ERR = 29, S_RXFL = 27, S_TXFL = 26;
  localparam int S_RXOV = 25, S_TXUN = 24, S_RXE = 23, S_RXF = 22, S_TXE = 21;
  localparam int S_TXF = 20, S_TXOV = 19, S_RXUN = 18;

  typedef struct packed {
    logic [4:0] len_m1;
    logic       cpha;
    logic       cpol;
  } frame_cfg_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign rdata_o = mem_q[rp_q];
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= PTR_W'(wp_q + 1'b1);
      if (do_pop)  rp_q <= PTR_W'(rp_q + 1'b1);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  // R6
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o && $stable(cnt_q));
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  frame_cfg_t       cfg_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [31:0]      tx_word_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [31:0]      rx_word_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  logic [4:0]       len_q;
  logic             cpha_q, busy_q, done_q, sclk_q, mosi_q;
  logic [DIV_W-1:0] div_q, hcnt_q;
  logic [6:0]       edge_q, edge_nxt, edge_tot;
  logic [31:0]      tsh_q, rsh_q, rx_q, rx_nxt, aligned;
  logic             tick, lead, last, sample, present;

  assign edge_tot = 7'(({2'b0, len_q} + 7'd1) << 1);
  assign edge_nxt = edge_q + 7'd1;
  assign tick     = busy_q && (hcnt_q == div_q);
  assign lead     = !edge_q[0];
  assign last     = (edge_nxt == edge_tot);
  assign sample   = cpha_q ? !lead : lead;
  assign present  = cpha_q ? lead : (!lead && !last);
  assign rx_nxt   = sample ? {rsh_q[30:0], miso_i} : rsh_q;
  assign aligned  = tx_word_i << (5'd31 - cfg_i.len_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0; cpha_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
      sclk_q <= 1'b0; mosi_q <= 1'b0; div_q <= '0; hcnt_q <= '0;
      edge_q <= '0; tsh_q <= '0; rsh_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        len_q  <= cfg_i.len_m1;
        cpha_q <= cfg_i.cpha;
        div_q  <= div_i;
        hcnt_q <= '0;
        edge_q <= '0;
        rsh_q  <= '0;
        if (cfg_i.cpha) begin
          tsh_q <= aligned;
        end else begin
          mosi_q <= aligned[31];
          tsh_q  <= aligned << 1;
        end
      end else if (tick) begin
        hcnt_q <= '0;
        edge_q <= edge_nxt;
        sclk_q <= !sclk_q;
        rsh_q  <= rx_nxt;
        if (present) begin
          mosi_q <= tsh_q[31];
          tsh_q  <= tsh_q << 1;
        end
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= rx_nxt;
        end
      end else if (busy_q) begin
        hcnt_q <= hcnt_q + 1'b1;
      end else begin
        sclk_q <= cfg_i.cpol;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_word_o = rx_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = mosi_q;

  // R5
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && $past(!busy_o) && $stable(cfg_i.cpol) && $past(!start_i) |-> sclk_o == cfg_i.cpol);
  // R2
  edge_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> edge_q < edge_tot);
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int NCS   = 4,
  parameter int DIV_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sclk_o,
  output logic              sclk_weak_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NCS-1:0]    cs_no
);
  // command / command2 state
  logic             en_q, go_q, ms_q, cpha_q, cs_pol_q, cs_val_q, cs_sw_q;
  logic [1:0]       idle_q;
  logic [4:0]       len_q;
  logic             rx_en_q, tx_en_q, keep_q, hw_cs_q;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic             rdy_q, rx_ov_q, tx_un_q, tx_ov_q, rx_un_q;

  logic wr, rd, wr_cmd, wr_cmd2, wr_stat, wr_div, wr_tx, rd_rx;
  logic busy, done;
  logic [31:0] rx_word, tx_head, rx_head, tx_word;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic tx_pop, rx_push, err;
  frame_cfg_t cfg;

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign wr_cmd  = wr && (addr_i == A_CMD);
  assign wr_cmd2 = wr && (addr_i == A_CMD2);
  assign wr_stat = wr && (addr_i == A_STAT);
  assign wr_div  = wr && (addr_i == A_DIV);
  assign wr_tx   = wr && (addr_i == A_TXP);
  assign rd_rx   = rd && (addr_i == A_RXP);

  assign tx_pop  = go_q && tx_en_q && !tx_empty;
  assign tx_word = (tx_en_q && !tx_empty) ? tx_head : '0;
  assign rx_push = done && rx_en_q;
  assign err     = rx_ov_q || tx_un_q || tx_ov_q || rx_un_q;
  assign cfg     = '{len_m1: len_q, cpha: cpha_q, cpol: idle_q[0]};

  spim_fifo #(.W(32), .DEPTH(DEPTH)) tx_fifo_i (
    .clk_i, .rst_ni,
    .flush_i (wr_stat && wdata_i[S_TXFL]),
    .push_i  (wr_tx), .wdata_i (wdata_i),
    .pop_i   (tx_pop), .rdata_o (tx_head),
    .full_o  (tx_full), .empty_o (tx_empty), .count_o (tx_cnt)
  );

  spim_fifo #(.W(32), .DEPTH(DEPTH)) rx_fifo_i (
    .clk_i, .rst_ni,
    .flush_i (wr_stat && wdata_i[S_RXFL]),
    .push_i  (rx_push), .wdata_i (rx_word),
    .pop_i   (rd_rx), .rdata_o (rx_head),
    .full_o  (rx_full), .empty_o (rx_empty), .count_o (rx_cnt)
  );

  spim_shift #(.DIV_W(DIV_W)) shift_i (
    .clk_i, .rst_ni,
    .start_i   (go_q),
    .cfg_i     (cfg),
    .div_i     (div_q),
    .tx_word_i (tx_word),
    .miso_i    (miso_i),
    .busy_o    (busy),
    .done_o    (done),
    .rx_word_o (rx_word),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; go_q <= 1'b0; ms_q <= 1'b0; cpha_q <= 1'b0;
      cs_pol_q <= 1'b0; cs_val_q <= 1'b0; cs_sw_q <= 1'b0;
      idle_q <= '0; len_q <= '0;
      rx_en_q <= 1'b0; tx_en_q <= 1'b0; keep_q <= 1'b0; sel_q <= '0;
      div_q <= '0; hw_cs_q <= 1'b0;
      rdy_q <= 1'b0; rx_ov_q <= 1'b0; tx_un_q <= 1'b0; tx_ov_q <= 1'b0; rx_un_q <= 1'b0;
    end else begin
      if (go_q) go_q <= 1'b0;
      if (wr_cmd) begin
        en_q     <= wdata_i[31];
        go_q     <= wdata_i[30] && wdata_i[31] && !busy && !go_q;
        ms_q     <= wdata_i[28];
        idle_q   <= wdata_i[25:24];
        cpha_q   <= wdata_i[21];
        cs_pol_q <= wdata_i[13];
        cs_val_q <= wdata_i[12];
        cs_sw_q  <= wdata_i[11];
        len_q    <= wdata_i[4:0];
      end
      if (wr_cmd2) begin
        rx_en_q <= wdata_i[31];
        tx_en_q <= wdata_i[30];
        sel_q   <= wdata_i[18 +: SEL_W];
        keep_q  <= wdata_i[17];
      end
      if (wr_div) div_q <= wdata_i[DIV_W-1:0];

      if (go_q)       hw_cs_q <= 1'b1;
      else if (!busy) hw_cs_q <= hw_cs_q && keep_q;

      // sticky events: set has priority over write-1-clear
      rdy_q   <= (rdy_q   && !(wr_stat && wdata_i[S_RDY]))  || done;
      rx_ov_q <= (rx_ov_q && !(wr_stat && wdata_i[S_RXOV])) || (rx_push && rx_full);
      tx_un_q <= (tx_un_q && !(wr_stat && wdata_i[S_TXUN])) || (go_q && tx_en_q && tx_empty);
      tx_ov_q <= (tx_ov_q && !(wr_stat && wdata_i[S_TXOV])) || (wr_tx && tx_full);
      rx_un_q <= (rx_un_q && !(wr_stat && wdata_i[S_RXUN])) || (rd_rx && rx_empty);
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CMD: begin
        rdata_o[31] = en_q;   rdata_o[30] = go_q;   rdata_o[28] = ms_q;
        rdata_o[25:24] = idle_q; rdata_o[21] = cpha_q;
        rdata_o[13] = cs_pol_q; rdata_o[12] = cs_val_q; rdata_o[11] = cs_sw_q;
        rdata_o[4:0] = len_q;
      end
      A_CMD2: begin
        rdata_o[31] = rx_en_q; rdata_o[30] = tx_en_q;
        rdata_o[18 +: SEL_W] = sel_q; rdata_o[17] = keep_q;
      end
      A_STAT: begin
        rdata_o[S_BUSY] = busy;     rdata_o[S_RDY]  = rdy_q;   rdata_o[S_ERR] = err;
        rdata_o[S_RXOV] = rx_ov_q;  rdata_o[S_TXUN] = tx_un_q;
        rdata_o[S_RXE]  = rx_empty; rdata_o[S_RXF]  = rx_full;
        rdata_o[S_TXE]  = tx_empty; rdata_o[S_TXF]  = tx_full;
        rdata_o[S_TXOV] = tx_ov_q;  rdata_o[S_RXUN] = rx_un_q;
      end
      A_DIV:   rdata_o[DIV_W-1:0] = div_q;
      A_STAT2: begin
        rdata_o[CNT_W-1:0]   = tx_cnt;
        rdata_o[16 +: CNT_W] = rx_cnt;
      end
      A_RXP:   rdata_o = rx_empty ? '0 : rx_head;
      default: rdata_o = '0;
    endcase
  end

  assign sclk_weak_o = idle_q[1] && !busy;

  logic cs_on;
  assign cs_on = cs_sw_q ? cs_val_q : hw_cs_q;

  for (genvar j = 0; j < NCS; j++) begin : g_cs
    logic act;
    assign act      = cs_on && (sel_q == SEL_W'(j));
    assign cs_no[j] = act ? cs_pol_q : !cs_pol_q;
  end

  // R3
  go_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !go_q);
  // R4
  ready_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |=> rdy_q);
  // R7
  rx_unr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rx && rx_empty |=> rx_un_q);
  // R6
  tx_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tx && tx_full |=> tx_ov_q);
  // R12
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_no ^ {NCS{!cs_pol_q}}));
endmodule

// File: tb/spim_ctrl_tb.sv
module spim_ctrl_tb_top;
  localparam logic [8:0] CMD = 9'h000, CMD2 = 9'h004, STAT = 9'h008, DIVR = 9'h00C;
  localparam logic [8:0] STAT2 = 9'h01C, TXP = 9'h100, RXP = 9'h180;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, sclk_weak, mosi, miso;
  logic [3:0] cs_n;
  logic inv = 1'b0;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  assign miso = mosi ^ inv;

  spim_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .sclk_weak_o(sclk_weak),
    .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  // wire monitor: collects MOSI at the sampling edge of the current mode
  logic mon_cpol = 1'b0, mon_cpha = 1'b0;
  logic [31:0] mon_word = '0;
  int mon_bits = 0;
  always @(sclk) begin
    if (rst_n && ((sclk != mon_cpol) != mon_cpha)) begin
      mon_word = {mon_word[30:0], mosi};
      mon_bits++;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
  endtask

  task automatic peek(input logic [8:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_cmd(input logic en, input logic go, input logic [1:0] idl,
      input logic ph, input logic pol, input logic val, input logic sw, input logic [4:0] len);
    logic [31:0] c;
    c = '0;
    c[31] = en; c[30] = go; c[25:24] = idl; c[21] = ph;
    c[13] = pol; c[12] = val; c[11] = sw; c[4:0] = len;
    return c;
  endfunction

  function automatic logic [31:0] mk_cmd2(input logic rx, input logic tx, input logic [1:0] sel, input logic keep);
    logic [31:0] c;
    c = '0;
    c[31] = rx; c[30] = tx; c[19:18] = sel; c[17] = keep;
    return c;
  endfunction

  function automatic logic [31:0] mask_of(input int len);
    return (len == 31) ? 32'hFFFF_FFFF : ((32'h1 << (len + 1)) - 1);
  endfunction

  // starts a frame with the given mode and returns cycles until busy falls
  task automatic frame(input int len, input logic [1:0] idl, input logic ph, output int n);
    logic [31:0] s;
    wr(CMD, mk_cmd(1'b1, 1'b0, idl, ph, 1'b0, 1'b0, 1'b0, 5'(len)));
    mon_cpol = idl[0]; mon_cpha = ph;
    idle(2);
    wr(CMD, mk_cmd(1'b1, 1'b1, idl, ph, 1'b0, 1'b0, 1'b0, 5'(len)));
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
      peek(STAT, s);
    end while (s[31] && n < 5000);
    idle(2);
  endtask

  task automatic rand_frame(input int len, input int d, input logic ph, input logic [1:0] idl,
                            input logic [31:0] tx, input logic iv);
    logic [31:0] s, r;
    int n, b0;
    inv = iv;
    wr(DIVR, 32'(d));
    wr(CMD2, mk_cmd2(1'b1, 1'b1, 2'd0, 1'b0));
    wr(TXP, tx);
    wr(CMD, mk_cmd(1'b1, 1'b0, idl, ph, 1'b0, 1'b0, 1'b0, 5'(len)));
    mon_cpol = idl[0]; mon_cpha = ph;
    idle(2);
    b0 = mon_bits;
    wr(CMD, mk_cmd(1'b1, 1'b1, idl, ph, 1'b0, 1'b0, 1'b0, 5'(len)));
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
      peek(STAT, s);
      if (n == 1) check("R4 busy during frame", 32'(s[31]), 32'd1);
    end while (s[31] && n < 5000);
    check("R5 frame duration", 32'(n), 32'(1 + 2 * (len + 1) * (d + 1)));
    check("R5 idle sclk level", 32'(sclk), 32'(idl[0]));
    idle(1);
    peek(STAT, s);
    check("R4 ready after frame", 32'(s[30]), 32'd1);
    check("R2 bit count on wire", 32'(mon_bits - b0), 32'(len + 1));
    check("R2 MOSI order", mon_word & mask_of(len), tx & mask_of(len));
    rd(RXP, r);
    check("R2 received word", r, (tx ^ {32{iv}}) & mask_of(len));
    rd(STAT, s);
    wr(STAT, s);
    inv = 1'b0;
  endtask

  initial begin
    #200000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // reset state
    peek(CMD, v);   check("R1 command reset", v, 32'h0);
    peek(CMD2, v);  check("R1 command2 reset", v, 32'h0);
    peek(STAT, v);  check("R1 status reset", v, 32'h00A0_0000);
    peek(STAT2, v); check("R1 counts reset", v, 32'h0);
    peek(DIVR, v);  check("R1 divider reset", v, 32'h0);
    check("R12 CS idle after reset", 32'(cs_n), 32'hF);

    // readback
    wr(CMD, 32'h9320_3805);
    peek(CMD, v);   check("R1 command readback", v, 32'h9320_3805 & ~32'h4000_0000);
    wr(CMD, 32'h0);

    // idle clock modes
    wr(CMD, mk_cmd(1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0)); idle(1);
    check("R5 idle mode 3 level", 32'({sclk, sclk_weak}), 32'd3);
    wr(CMD, mk_cmd(1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0)); idle(1);
    check("R5 idle mode 2 level", 32'({sclk, sclk_weak}), 32'd1);
    wr(CMD, mk_cmd(1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0)); idle(1);
    check("R5 idle mode 1 level", 32'({sclk, sclk_weak}), 32'd2);
    wr(CMD, 32'h0); idle(1);
    check("R5 idle mode 0 level", 32'({sclk, sclk_weak}), 32'd0);

    // TX overflow, error, write-back clear, flush
    for (int i = 0; i < 5; i++) wr(TXP, 32'(i + 100));
    peek(STAT2, v); check("R6 TX count full", v & 32'h7, 32'd4);
    peek(STAT, v);
    check("R6 TX full flag", 32'(v[20]), 32'd1);
    check("R6 TX overflow flag", 32'(v[19]), 32'd1);
    check("R9 error on overflow", 32'(v[29]), 32'd1);
    wr(STAT, v);
    peek(STAT, v);
    check("R8 write-back clears events", v & 32'h7F0C_0000, 32'h0);
    check("R9 error cleared", 32'(v[29]), 32'd0);
    peek(STAT2, v); check("R14 write-back does not flush", v & 32'h7, 32'd4);
    wr(STAT, 32'h0400_0000);
    peek(STAT2, v); check("R14 TX flush", v & 32'h7, 32'd0);

    // RX underrun
    rd(RXP, v);     check("R7 empty read returns 0", v, 32'h0);
    peek(STAT, v);
    check("R7 RX underrun flag", 32'(v[18]), 32'd1);
    check("R9 error on underrun", 32'(v[29]), 32'd1);
    wr(STAT, 32'h0004_0000);
    peek(STAT, v);  check("R8 W1C underrun", 32'(v[18]), 32'd0);

    // directed frames at the length extremes
    rand_frame(0, 0, 1'b0, 2'd0, 32'h0000_0001, 1'b0);
    rand_frame(31, 1, 1'b1, 2'd1, 32'hA5C3_0F81, 1'b1);
    rand_frame(7, 2, 1'b1, 2'd3, 32'h1234_56C5, 1'b0);

    // random frames
    for (int k = 0; k < 24; k++) begin
      rand_frame(int'($urandom % 32), int'($urandom % 4), 1'($urandom), 2'($urandom),
                 $urandom, 1'($urandom));
    end

    // RX overflow: five frames without reading
    wr(DIVR, 32'd0);
    wr(CMD2, mk_cmd2(1'b1, 1'b1, 2'd0, 1'b0));
    for (int i = 0; i < 5; i++) begin
      wr(TXP, 32'(8'h30 + i));
      frame(7, 2'd0, 1'b0, n);
    end
    peek(STAT2, v); check("R7 RX count full", (v >> 16) & 32'h7, 32'd4);
    peek(STAT, v);
    check("R7 RX overflow flag", 32'(v[25]), 32'd1);
    check("R7 RX full flag", 32'(v[22]), 32'd1);
    rd(RXP, v);     check("R7 oldest word kept", v, 32'h30);
    wr(STAT, 32'h0800_0000);
    peek(STAT2, v); check("R14 RX flush", v, 32'h0);
    peek(STAT, v); wr(STAT, v);

    // start while busy ignored
    wr(DIVR, 32'd3);
    wr(TXP, 32'h1111_1111);
    wr(TXP, 32'h2222_2222);
    wr(CMD, mk_cmd(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd31));
    idle(3);
    wr(CMD, mk_cmd(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd31));
    peek(CMD, v);   check("R3 start while busy not kept", 32'(v[30]), 32'd0);
    idle(400);
    peek(STAT2, v);
    check("R3 one TX word consumed", v & 32'h7, 32'd1);
    check("R3 one RX word produced", (v >> 16) & 32'h7, 32'd1);

    // start with enable 0 ignored
    wr(STAT, 32'h0C00_0000);
    wr(DIVR, 32'd0);
    wr(TXP, 32'h0000_00AA);
    wr(CMD, mk_cmd(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd7));
    idle(40);
    peek(STAT2, v); check("R3 disabled start no frame", v, 32'd1);
    wr(STAT, 32'h0400_0000);

    // TX underrun
    frame(7, 2'd0, 1'b0, n);
    peek(STAT, v);  check("R10 TX underrun flag", 32'(v[24]), 32'd1);
    rd(RXP, v);     check("R10 zeros shifted", v, 32'h0);
    peek(STAT, v); wr(STAT, v);

    // transmit / receive enables
    wr(CMD2, mk_cmd2(1'b1, 1'b0, 2'd0, 1'b0));
    wr(TXP, 32'h0000_00FF);
    frame(7, 2'd0, 1'b0, n);
    peek(STAT2, v); check("R11 TX disabled keeps queue", v & 32'h7, 32'd1);
    rd(RXP, v);     check("R11 TX disabled sends zeros", v, 32'h0);
    wr(CMD2, mk_cmd2(1'b0, 1'b1, 2'd0, 1'b0));
    frame(7, 2'd0, 1'b0, n);
    peek(STAT2, v); check("R11 RX disabled no push", v, 32'h0);

    // software chip select
    wr(CMD2, mk_cmd2(1'b1, 1'b1, 2'd2, 1'b0));
    wr(CMD, mk_cmd(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd7));
    check("R12 SW CS low active", 32'(cs_n), 32'b1011);
    wr(CMD, mk_cmd(1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd7));
    check("R12 SW CS high active", 32'(cs_n), 32'b0100);
    wr(CMD, mk_cmd(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd7));
    check("R12 SW CS released", 32'(cs_n), 32'hF);

    // hardware chip select
    wr(CMD2, mk_cmd2(1'b1, 1'b1, 2'd1, 1'b0));
    wr(DIVR, 32'd2);
    wr(TXP, 32'h5A);
    wr(CMD, mk_cmd(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd7));
    idle(4);
    check("R13 HW CS during frame", 32'(cs_n), 32'b1101);
    idle(80);
    check("R13 HW CS after frame", 32'(cs_n), 32'hF);
    wr(CMD2, mk_cmd2(1'b1, 1'b1, 2'd1, 1'b1));
    wr(TXP, 32'h5A);
    wr(CMD, mk_cmd(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd7));
    idle(80);
    check("R13 HW CS kept", 32'(cs_n), 32'b1101);
    wr(CMD2, mk_cmd2(1'b1, 1'b1, 2'd1, 1'b0));
    idle(1);
    check("R13 HW CS dropped", 32'(cs_n), 32'hF);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule